// File: doc/BRIEF.md
# Dual-Bank Flash Command Decoder

This block turns a stream of host bus-write cycles, each a word address plus a 16-bit data word, into flash commands. It sits between the host write path and a separate program/erase engine. Each of the two banks keeps its own read mode: array, status, signature or query. A read path elsewhere uses that mode to choose what a bus read returns. Multi-cycle sequences are decoded here: single-word, double-word and quad-word program, block and bank erase, lock, unlock, lock-down, configuration and protection-register program. For each accepted sequence the block sends the engine a one-cycle start request that carries an operation code, an address and up to four data words.

The engine reports back two flags, busy and suspended. The decoder uses them for three things. It filters commands aimed at the bank that is working. It lets the other bank keep serving reads. It limits what may be issued while an operation is paused. A bank is chosen by comparing the address with a parameterised split point; bank 0 lies below the split.

Top module: `flash_cmd_dec`

## Requirements
- R1: After reset, every bank is in array mode (encoding 0), all error bits are 0 and `start_o` is low.
- R2: A write whose low data byte is FFh, 70h, 90h or 98h sets the read mode of the addressed bank to array (0), status (1), signature (2) or query (3). The other bank is unchanged. Bank b's mode sits at `rd_mode_o[2b+1:2b]`. The high data byte is ignored in command codes.
- R3: An address below `BANK_SPLIT` selects bank 0. An address at or above it selects bank 1.
- R4: Setup 40h or 10h, followed by one address/data write, issues a start with op 1 and that address, with the data in word 0. The target bank enters status mode. The start is seen in the cycle after the second write.
- R5: Setup 20h or 80h, followed by D0h, issues op 4 (block erase) or op 5 (bank erase) at the second-cycle address. Any other second value issues no start. It sets both error bits of that bank (`err_o[2b+1]` for erase, `err_o[2b]` for program) and puts the bank in status mode.
- R6: After 60h, the second cycle selects the operation. 01h gives op 6 (lock), D0h gives op 7 (unlock) and 2Fh gives op 8 (lock-down); each uses the second-cycle address. 03h gives op 9 (configuration): word 0 carries the low 16 address bits and the bank returns to array mode. Any other value issues no start and sets array mode.
- R7: 30h, then two address/data writes, issues op 2. 55h, then four writes, issues op 3. The start address is the first address, and data word k is at `op_data_o[16k+15:16k]`. A later address that differs from the first above bit 0 (double) or above bit 1 (quad) cancels the sequence, issues no start and sets array mode.
- R8: While the engine is busy and not suspended, the bank of its operation ignores FFh and 90h and accepts 70h. B0h there issues op 11 (suspend), but not during a bank erase.
- R9: 98h written to the working bank leaves it in status mode. When busy falls, that bank switches to query mode.
- R10: While an operation runs, the other bank accepts read-mode commands. A program, erase or lock setup to it is invalid: no start, and array mode.
- R11: While suspended, D0h to the suspended bank issues op 12 (resume) and sets status mode. A program may be issued during a suspended block erase. After a suspended program, a program setup is invalid.
- R12: 50h clears both error bits of the addressed bank and sets array mode.
- R13: An unknown command code sets the addressed bank to array mode and issues no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Bus-write cycle valid |
| addr_i | input | AW | Word address of the write |
| data_i | input | DW | Write data / command code (low byte) |
| busy_i | input | 1 | Engine has an operation in progress |
| susp_i | input | 1 | Engine operation is paused |
| start_o | output | 1 | One-cycle start request to the engine |
| op_o | output | 4 | Operation code of the request |
| op_addr_o | output | AW | Operation address |
| op_data_o | output | 4*DW | Operation data, word k at bits [DW*k+DW-1:DW*k] |
| rd_mode_o | output | 4 | Per-bank read mode, 2 bits per bank |
| err_o | output | 4 | Per-bank {erase error, program error} |

## Verification
The bench builds the decoder with a 12-bit address and the bank split at 400h. This puts the boundary at 3FFh/400h in easy reach, and keeps the page-adjacency compare on a small address. The engine flags are driven by hand from the bench. The suspend, resume, nested-program and completion-to-query paths can then be walked cycle by cycle, with no model of the engine.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned PAGE_WORDS = 4;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_SIG    = 2'd2,
    RM_QUERY  = 2'd3
  } rmode_e;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_PROG       = 4'd1,
    OP_PROG2      = 4'd2,
    OP_PROG4      = 4'd3,
    OP_BLK_ERASE  = 4'd4,
    OP_BANK_ERASE = 4'd5,
    OP_LOCK       = 4'd6,
    OP_UNLOCK     = 4'd7,
    OP_LOCKDOWN   = 4'd8,
    OP_CFG        = 4'd9,
    OP_OTP        = 4'd10,
    OP_SUSPEND    = 4'd11,
    OP_RESUME     = 4'd12
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ERASE, SQ_LOCK, SQ_PROG, SQ_OTP, SQ_MULTI
  } seq_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_RD_SIG   = 8'h90;
  localparam logic [7:0] C_RD_QRY   = 8'h98;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_SUSPEND  = 8'hB0;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_PROG     = 8'h40;
  localparam logic [7:0] C_PROG_ALT = 8'h10;
  localparam logic [7:0] C_PROG2    = 8'h30;
  localparam logic [7:0] C_PROG4    = 8'h55;
  localparam logic [7:0] C_BLK_ERS  = 8'h20;
  localparam logic [7:0] C_BANK_ERS = 8'h80;
  localparam logic [7:0] C_LOCK_SET = 8'h60;
  localparam logic [7:0] C_OTP      = 8'hC0;
  localparam logic [7:0] C_LOCK     = 8'h01;
  localparam logic [7:0] C_LOCKDOWN = 8'h2F;
  localparam logic [7:0] C_CFG      = 8'h03;
endpackage

// File: rtl/flash_bank_sel.sv
module flash_bank_sel #(
  parameter int unsigned AW         = 22,
  parameter int unsigned BANK_SPLIT = 1 << (AW - 2)
) (
  input  logic [AW-1:0] addr_i,
  output logic          bank_o
);
  localparam logic [AW-1:0] SPLIT = AW'(BANK_SPLIT);
  assign bank_o = (addr_i >= SPLIT);
endmodule

// File: rtl/flash_page_check.sv
module flash_page_check #(
  parameter int unsigned AW = 22
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  input  logic          quad_i,
  output logic          match_o
);
  logic [AW-1:0] mask;
  assign mask    = quad_i ? ~AW'(3) : ~AW'(1);
  assign match_o = (((base_i ^ addr_i) & mask) == '0);
endmodule

// File: rtl/flash_bank_state.sv
module flash_bank_state
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  rmode_e     mode_i,
  input  logic       pend_set_i,
  input  logic       done_i,
  input  logic       err_set_i,
  input  logic       err_clr_i,
  output rmode_e     mode_o,
  output logic [1:0] err_o
);
  rmode_e     mode_q;
  logic       pend_q;
  logic [1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RM_ARRAY;
      pend_q <= 1'b0;
      err_q  <= 2'b00;
    end else begin
      if (we_i) mode_q <= mode_i;
      else if (done_i && pend_q) mode_q <= RM_QUERY;
      if (done_i) pend_q <= 1'b0;
      else if (pend_set_i) pend_q <= 1'b1;
      if (err_set_i) err_q <= 2'b11;
      else if (err_clr_i) err_q <= 2'b00;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  a_r12_clear_errors: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !err_set_i |=> err_o == 2'b00);
  a_r9_query_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && pend_q && !we_i |=> mode_o == RM_QUERY);
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW         = 22,
  parameter int unsigned DW         = 16,
  parameter int unsigned BANK_SPLIT = 1 << (AW - 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            data_i,
  input  logic                     busy_i,
  input  logic                     susp_i,
  output logic                     start_o,
  output logic [3:0]               op_o,
  output logic [AW-1:0]            op_addr_o,
  output logic [PAGE_WORDS*DW-1:0] op_data_o,
  output logic [3:0]               rd_mode_o,
  output logic [3:0]               err_o
);
  localparam int unsigned NB = 2;
  localparam int unsigned PW = PAGE_WORDS;
  localparam int unsigned CW = $clog2(PW);

  logic [7:0] cmd;
  logic       bank_w, page_ok;
  assign cmd = data_i[7:0];

  flash_bank_sel #(.AW(AW), .BANK_SPLIT(BANK_SPLIT)) u_bsel (
    .addr_i(addr_i), .bank_o(bank_w));

  seq_e                   seq_q, seq_d;
  logic                   quad_q, quad_d, ers_bank_q, ers_bank_d, cfg_ok_q, cfg_ok_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic [AW-1:0]          base_q, base_d;
  logic [PW-1:0][DW-1:0]  words_q, words_d;
  op_e                    act_q;
  logic                   act_bank_q, busy_q;
  logic                   start_q, start_d;
  op_e                    op_q, op_d;
  logic [AW-1:0]          addr_q, addr_d;
  logic [PW*DW-1:0]       data_q, data_d;

  flash_page_check #(.AW(AW)) u_page (
    .base_i(base_q), .addr_i(addr_i), .quad_i(quad_q), .match_o(page_ok));

  logic       eng_run, eng_sus, tgt_run, mod_ok, invalid, done;
  logic [CW-1:0] last_idx;
  logic [NB-1:0] mode_we, pend_set, err_set, err_clr, done_b;
  rmode_e     mode_val [NB];
  rmode_e     mode_b   [NB];
  logic [1:0] err_b    [NB];
  logic [DW-1:0] cfg_word;

  assign eng_run  = busy_i & ~susp_i;
  assign eng_sus  = busy_i & susp_i;
  assign tgt_run  = eng_run & (act_bank_q == bank_w);
  // modifying commands: engine idle, or paused in a block erase
  assign mod_ok   = !eng_run && (!eng_sus || act_q == OP_BLK_ERASE);
  assign last_idx = quad_q ? CW'(PW - 1) : CW'(1);
  assign cfg_word = DW'(addr_i);
  assign done     = busy_q & ~busy_i;

  always_comb begin
    seq_d = seq_q; quad_d = quad_q; cnt_d = cnt_q; base_d = base_q;
    words_d = words_q; ers_bank_d = ers_bank_q; cfg_ok_d = cfg_ok_q;
    start_d = 1'b0; op_d = OP_NONE; addr_d = '0; data_d = '0;
    mode_we = '0; pend_set = '0; err_set = '0; err_clr = '0;
    for (int b = 0; b < NB; b++) mode_val[b] = RM_ARRAY;
    invalid = 1'b0;
    if (wr_i) begin
      if (seq_q == SQ_IDLE) begin
        if (tgt_run) begin
          case (cmd)
            C_RD_STAT: begin mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_STATUS; end
            C_RD_QRY:  pend_set[bank_w] = 1'b1;
            C_SUSPEND: if (act_q != OP_BANK_ERASE) begin
              start_d = 1'b1; op_d = OP_SUSPEND; addr_d = addr_i;
            end
            default: ;
          endcase
        end else begin
          case (cmd)
            C_RD_ARRAY: begin mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_ARRAY;  end
            C_RD_STAT:  begin mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_STATUS; end
            C_RD_SIG:   begin mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_SIG;    end
            C_RD_QRY:   begin mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_QUERY;  end
            C_CLR_STAT: if (mod_ok) begin
              err_clr[bank_w] = 1'b1; mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_ARRAY;
            end else invalid = 1'b1;
            C_PROG, C_PROG_ALT: if (mod_ok) seq_d = SQ_PROG; else invalid = 1'b1;
            C_OTP:      if (mod_ok) seq_d = SQ_OTP; else invalid = 1'b1;
            C_LOCK_SET: if (mod_ok) begin seq_d = SQ_LOCK; cfg_ok_d = !eng_sus; end
                        else invalid = 1'b1;
            C_BLK_ERS, C_BANK_ERS: if (!busy_i) begin
              seq_d = SQ_ERASE; ers_bank_d = (cmd == C_BANK_ERS);
            end else invalid = 1'b1;
            C_PROG2, C_PROG4: if (!busy_i) begin
              seq_d = SQ_MULTI; quad_d = (cmd == C_PROG4); cnt_d = '0;
            end else invalid = 1'b1;
            C_CONFIRM: if (eng_sus && act_bank_q == bank_w) begin
              start_d = 1'b1; op_d = OP_RESUME; addr_d = addr_i;
              mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_STATUS;
            end else invalid = 1'b1;
            default: invalid = 1'b1;
          endcase
        end
      end else begin
        seq_d = SQ_IDLE;
        if (eng_run) invalid = 1'b1;
        else begin
          case (seq_q)
            SQ_ERASE: begin
              mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_STATUS;
              if (cmd == C_CONFIRM) begin
                start_d = 1'b1; addr_d = addr_i;
                op_d = ers_bank_q ? OP_BANK_ERASE : OP_BLK_ERASE;
              end else err_set[bank_w] = 1'b1;
            end
            SQ_LOCK: begin
              addr_d = addr_i;
              case (cmd)
                C_LOCK:     begin start_d = 1'b1; op_d = OP_LOCK;     end
                C_CONFIRM:  begin start_d = 1'b1; op_d = OP_UNLOCK;   end
                C_LOCKDOWN: begin start_d = 1'b1; op_d = OP_LOCKDOWN; end
                C_CFG: if (cfg_ok_q) begin
                  start_d = 1'b1; op_d = OP_CFG; data_d[DW-1:0] = cfg_word;
                  mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_ARRAY;
                end else invalid = 1'b1;
                default: invalid = 1'b1;
              endcase
            end
            SQ_PROG, SQ_OTP: begin
              start_d = 1'b1; addr_d = addr_i; data_d[DW-1:0] = data_i;
              op_d = (seq_q == SQ_OTP) ? OP_OTP : OP_PROG;
              mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_STATUS;
            end
            SQ_MULTI: begin
              if (cnt_q != '0 && !page_ok) invalid = 1'b1;
              else begin
                words_d[cnt_q] = data_i;
                if (cnt_q == '0) base_d = addr_i;
                if (cnt_q == last_idx) begin
                  start_d = 1'b1; addr_d = base_q;
                  op_d = quad_q ? OP_PROG4 : OP_PROG2;
                  for (int k = 0; k < PW; k++)
                    data_d[k*DW +: DW] = (CW'(k) == cnt_q) ? data_i :
                                         (CW'(k) < cnt_q)  ? words_q[k] : '0;
                  mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_STATUS;
                end else begin
                  cnt_d = cnt_q + 1'b1; seq_d = SQ_MULTI;
                end
              end
            end
            default: invalid = 1'b1;
          endcase
        end
      end
      if (invalid) begin
        seq_d = SQ_IDLE; start_d = 1'b0;
        mode_we[bank_w] = 1'b1; mode_val[bank_w] = RM_ARRAY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SQ_IDLE; quad_q <= 1'b0; cnt_q <= '0; base_q <= '0; words_q <= '0;
      ers_bank_q <= 1'b0; cfg_ok_q <= 1'b0; act_q <= OP_NONE; act_bank_q <= 1'b0;
      busy_q <= 1'b0; start_q <= 1'b0; op_q <= OP_NONE; addr_q <= '0; data_q <= '0;
    end else begin
      seq_q <= seq_d; quad_q <= quad_d; cnt_q <= cnt_d; base_q <= base_d;
      words_q <= words_d; ers_bank_q <= ers_bank_d; cfg_ok_q <= cfg_ok_d;
      busy_q <= busy_i;
      start_q <= start_d; op_q <= op_d; addr_q <= addr_d; data_q <= data_d;
      // a start issued during a pause leaves the paused operation tracked
      if (start_d && !eng_sus && op_d != OP_SUSPEND && op_d != OP_RESUME) begin
        act_q <= op_d; act_bank_q <= bank_w;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign done_b[b] = done && (act_bank_q == 1'(b));
    flash_bank_state u_state (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mode_we[b]), .mode_i(mode_val[b]),
      .pend_set_i(pend_set[b]), .done_i(done_b[b]), .err_set_i(err_set[b]),
      .err_clr_i(err_clr[b]), .mode_o(mode_b[b]), .err_o(err_b[b]));
    assign rd_mode_o[2*b +: 2] = mode_b[b];
    assign err_o[2*b +: 2]     = err_b[b];
  end

  assign start_o   = start_q;
  assign op_o      = op_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;

  logic op_bank;
  assign op_bank = (op_addr_o >= AW'(BANK_SPLIT));

  a_r4_status_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && (op_q inside {OP_PROG, OP_PROG2, OP_PROG4, OP_BLK_ERASE, OP_BANK_ERASE, OP_OTP})
    |-> mode_b[op_bank] == RM_STATUS);
  a_r8_run_only_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && $past(busy_i && !susp_i) |-> op_q == OP_SUSPEND);
  a_r5_bad_confirm_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_set) |=> !start_o);
  a_r8_no_bank_erase_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && op_q == OP_SUSPEND |-> $past(act_q) != OP_BANK_ERASE);
endmodule

// File: tb/flash_cmd_dec_test.sv
`timescale 1ns/1ps
module flash_cmd_dec_test;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, busy = 1'b0, susp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic start;
  logic [3:0] op, rd_mode, err;
  logic [AW-1:0] op_addr;
  logic [4*DW-1:0] op_data;
  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  flash_cmd_dec #(.AW(AW), .DW(DW), .BANK_SPLIT(32'h400)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .busy_i(busy), .susp_i(susp), .start_o(start), .op_o(op), .op_addr_o(op_addr),
    .op_data_o(op_data), .rd_mode_o(rd_mode), .err_o(err));

  typedef struct packed {
    logic [11:0] a;
    logic [15:0] d;
    logic        st;
    logic [3:0]  op;
    logic [3:0]  md;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{12'h010, 16'h0090, 1'b0, 4'd0, 4'b0010},
    '{12'h810, 16'h0098, 1'b0, 4'd0, 4'b1110},
    '{12'h000, 16'h00FF, 1'b0, 4'd0, 4'b1100},
    '{12'h800, 16'h0070, 1'b0, 4'd0, 4'b0100},
    '{12'h020, 16'h0040, 1'b0, 4'd0, 4'b0100},
    '{12'h021, 16'h1234, 1'b1, 4'd1, 4'b0101},
    '{12'h820, 16'h0020, 1'b0, 4'd0, 4'b0101},
    '{12'h820, 16'h00D0, 1'b1, 4'd4, 4'b0101},
    '{12'h100, 16'h0060, 1'b0, 4'd0, 4'b0101},
    '{12'h155, 16'h0003, 1'b1, 4'd9, 4'b0100},
    '{12'h000, 16'h0090, 1'b0, 4'd0, 4'b0110},
    '{12'h000, 16'h0077, 1'b0, 4'd0, 4'b0100}
  };
  localparam string TAG [12] = '{"R2", "R2", "R2", "R2", "R4", "R4",
                                 "R5", "R5", "R6", "R6", "R13", "R13"};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cyc(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    addr = a; data = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic chk_start(string req, logic [3:0] exp_op);
    chk(req, {63'd0, start}, 64'd1);
    chk(req, {60'd0, op}, {60'd0, exp_op});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {56'd0, rd_mode, err}, 64'd0);
    chk("R1", {63'd0, start}, 64'd0);

    for (int i = 0; i < 12; i++) begin
      wr_cyc(VEC[i].a, VEC[i].d);
      chk(TAG[i], {63'd0, start}, {63'd0, VEC[i].st});
      if (VEC[i].st) chk(TAG[i], {60'd0, op}, {60'd0, VEC[i].op});
      chk(TAG[i], {60'd0, rd_mode}, {60'd0, VEC[i].md});
    end
    // R6: configuration word comes from the address
    wr_cyc(12'h100, 16'h0060); wr_cyc(12'h2A5, 16'h0003);
    chk("R6", op_data, 64'h0000_0000_0000_02A5);

    // R3 boundary
    wr_cyc(12'h3FF, 16'h0090); chk("R3", {60'd0, rd_mode}, 64'b0110);
    wr_cyc(12'h400, 16'h0090); chk("R3", {60'd0, rd_mode}, 64'b1010);

    // R7 quad and double
    wr_cyc(12'h040, 16'h0055);
    wr_cyc(12'h040, 16'hA0A0); chk("R7", {63'd0, start}, 64'd0);
    wr_cyc(12'h041, 16'hA1A1);
    wr_cyc(12'h042, 16'hA2A2);
    wr_cyc(12'h043, 16'hA3A3);
    chk_start("R7", 4'd3);
    chk("R7", {52'd0, op_addr}, 64'h040);
    chk("R7", op_data, 64'hA3A3_A2A2_A1A1_A0A0);
    chk("R7", {60'd0, rd_mode}, 64'b1001);
    wr_cyc(12'h061, 16'h0030); wr_cyc(12'h061, 16'h1111); wr_cyc(12'h060, 16'h2222);
    chk_start("R7", 4'd2);
    chk("R7", {52'd0, op_addr}, 64'h061);
    chk("R7", op_data, 64'h0000_0000_2222_1111);
    wr_cyc(12'h050, 16'h0030); wr_cyc(12'h050, 16'h0001); wr_cyc(12'h052, 16'h0002);
    chk("R7", {63'd0, start}, 64'd0);
    chk("R7", {60'd0, rd_mode}, 64'b1000);

    // R5 bad confirm, R12 clear
    wr_cyc(12'h800, 16'h0020); wr_cyc(12'h800, 16'h00FF);
    chk("R5", {63'd0, start}, 64'd0);
    chk("R5", {60'd0, err}, 64'b1100);
    chk("R5", {60'd0, rd_mode}, 64'b0100);
    wr_cyc(12'h800, 16'h0050);
    chk("R12", {60'd0, err}, 64'd0);
    chk("R12", {60'd0, rd_mode}, 64'd0);

    // R6 lock family
    wr_cyc(12'h010, 16'h0060); wr_cyc(12'h010, 16'h002F); chk_start("R6", 4'd8);
    wr_cyc(12'h010, 16'h0060); wr_cyc(12'h020, 16'h00D0); chk_start("R6", 4'd7);
    chk("R6", {52'd0, op_addr}, 64'h020);
    wr_cyc(12'h010, 16'h0060); wr_cyc(12'h010, 16'h0001); chk_start("R6", 4'd6);
    wr_cyc(12'h010, 16'h0060); wr_cyc(12'h010, 16'h0099);
    chk("R6", {63'd0, start}, 64'd0);

    // busy block erase in bank 1
    wr_cyc(12'h800, 16'h0020); wr_cyc(12'h830, 16'h00D0);
    chk_start("R5", 4'd4);
    chk("R5", {60'd0, rd_mode}, 64'b0100);
    @(negedge clk); busy = 1'b1;
    wr_cyc(12'h800, 16'h00FF); chk("R8", {60'd0, rd_mode}, 64'b0100);
    wr_cyc(12'h800, 16'h0090); chk("R8", {60'd0, rd_mode}, 64'b0100);
    wr_cyc(12'h800, 16'h0098); chk("R9", {60'd0, rd_mode}, 64'b0100);
    wr_cyc(12'h000, 16'h0090); chk("R10", {60'd0, rd_mode}, 64'b0110);
    wr_cyc(12'h000, 16'h0040);
    chk("R10", {63'd0, start}, 64'd0);
    chk("R10", {60'd0, rd_mode}, 64'b0100);
    wr_cyc(12'h000, 16'h0020); chk("R10", {63'd0, start}, 64'd0);
    wr_cyc(12'h800, 16'h00B0); chk_start("R8", 4'd11);
    @(negedge clk); susp = 1'b1;
    wr_cyc(12'h000, 16'h0040); wr_cyc(12'h005, 16'hBEEF);
    chk_start("R11", 4'd1);
    chk("R11", op_data, 64'h0000_0000_0000_BEEF);
    chk("R11", {60'd0, rd_mode}, 64'b0101);
    wr_cyc(12'h800, 16'h00D0); chk_start("R11", 4'd12);
    chk("R11", {60'd0, rd_mode}, 64'b0101);
    @(negedge clk); susp = 1'b0;
    @(negedge clk); busy = 1'b0;
    @(negedge clk);
    chk("R9", {60'd0, rd_mode}, 64'b1101);

    // R8 bank erase cannot be suspended
    wr_cyc(12'h800, 16'h0080); wr_cyc(12'h800, 16'h00D0); chk_start("R5", 4'd5);
    @(negedge clk); busy = 1'b1;
    wr_cyc(12'h800, 16'h00B0); chk("R8", {63'd0, start}, 64'd0);
    @(negedge clk); busy = 1'b0;

    // R11 program suspend allows no program setup
    wr_cyc(12'h000, 16'h0040); wr_cyc(12'h000, 16'h1234); chk_start("R4", 4'd1);
    @(negedge clk); busy = 1'b1;
    wr_cyc(12'h000, 16'h00B0); chk_start("R8", 4'd11);
    @(negedge clk); susp = 1'b1;
    wr_cyc(12'h000, 16'h0040);
    chk("R11", {63'd0, start}, 64'd0);
    chk("R11", {62'd0, rd_mode[1:0]}, 64'd0);
    wr_cyc(12'h000, 16'h00D0); chk_start("R11", 4'd12);
    @(negedge clk); susp = 1'b0; busy = 1'b0;
    @(negedge clk);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule